// File: doc/BRIEF.md
# Tagged Custom-Operation Dispatch Controller

This block sits beside a processor register file and issues custom operations to a small array of stateless, reconfigurable compute rows. The block keeps a live shadow copy of the register file, and every row reads three of those registers directly. Each row holds a loaded operation tag, a function select and a settle latency. When the pipeline presents a custom-op tag, the block compares it with the tags of all loaded rows at once. It drives the result of the matching row onto the writeback stream once that row has settled. It stalls while the row is still settling, and it reports a configuration miss when no row holds the tag.

Settling is modelled with a per-row down-counter. A row's counter restarts on a load of that row and on a write to any register the row reads. Rows are loaded one at a time through a plain configuration port. The row logic is a fixed set of three-operand functions.

The issue side is a valid/ready stream, and so is the writeback side. The rules for back-pressure are as follows. `wb_valid` is high only while an op is presented, its tag hits a row, and that row has settled. An op is consumed, with `op_ready` high, in exactly the cycle in which `wb_valid` and `wb_ready` are both high. While `wb_ready` is low, the op is not consumed and the caller must hold it. The result tracks the current register values during the hold.

Top module: `cop_dispatch`

## Requirements
- R1: After reset no row is loaded, so any presented op reports a miss, `wb_valid` and `op_ready` are low, and `dup_err` is low.
- R2: An op hits a row when the row is loaded and its stored tag equals `op_tag`. `wb_row` gives the index of the selected row.
- R3: While `op_valid` is high and no loaded row holds `op_tag`, `cfg_miss` is high and `op_ready` is low. A load of a row with that tag, written in cycle c, clears the miss in cycle c+1.
- R4: A load of row r, or a register write to one of row r's sources in cycle c, keeps row r unsettled for cycles c+1 through c+L, where L is the row's latency. The row is settled from cycle c+1+L on. When L is 0, the row is settled at c+1.
- R5: Row r reads registers r, r+1 and r+2 (modulo the register count) as operands a, b and c. A write to any other register does not delay row r.
- R6: The function select picks the row's result: 0 gives a+b+c, 1 gives a^b^c, 2 gives a with its bits reversed, and 3 gives (a&b)|c. Each result is truncated to the data width.
- R7: If more than one loaded row holds `op_tag`, `dup_err` is high and the row with the lowest index is selected.
- R8: `op_ready` equals `wb_valid && wb_ready`, and `pipe_stall` equals `op_valid && !op_ready`. Back-to-back ops on different rows are each accepted in one cycle.
- R9: Rows hold no operand state. After a source register is written and the row has settled, the result reflects the new register value.
- R10: A load replaces the row's previous tag, so the old tag no longer hits that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_we | input | 1 | Register-file write strobe (shadow copy) |
| rf_waddr | input | 3 | Register index written |
| rf_wdata | input | 16 | Register value written |
| ld_we | input | 1 | Row load strobe |
| ld_row | input | 2 | Row being loaded |
| ld_tag | input | 6 | Op tag stored in the row |
| ld_fn | input | 2 | Function select stored in the row |
| ld_lat | input | 4 | Settle latency in cycles |
| op_valid | input | 1 | Custom op presented |
| op_ready | output | 1 | Op consumed this cycle |
| op_tag | input | 6 | Tag of the presented op |
| wb_valid | output | 1 | Writeback result available |
| wb_ready | input | 1 | Writeback sink accepts |
| wb_data | output | 16 | Result of the selected row (zero when not valid) |
| wb_row | output | 2 | Index of the selected row |
| pipe_stall | output | 1 | Presented op not consumed this cycle |
| cfg_miss | output | 1 | Presented tag held by no loaded row |
| dup_err | output | 1 | Presented tag held by more than one row |

## Verification
The hardest situation to reach is a late operand. This is a register write that lands on a row's source while an op for that row is waiting. The stall has to last exactly the row's latency, and the released result has to carry the new value. The bench writes a source register, holds the op on the next cycle, and counts stalled cycles until `wb_valid` rises. It then compares both the count and the data with a model built from a mirror of the register writes. A second corner is a miss resolved by a load issued while the op is still held. The bench drives the load in the same cycle as the missing op and checks that the miss is still visible in that cycle and gone in the next.

// File: rtl/cop_pkg.sv
package cop_pkg;
  typedef enum logic [1:0] {
    FN_SUM3  = 2'd0,
    FN_XOR3  = 2'd1,
    FN_REV   = 2'd2,
    FN_ANDOR = 2'd3
  } cop_fn_e;
endpackage

// File: rtl/cop_shadow_rf.sv
module cop_shadow_rf #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [RA_W-1:0]          wr_addr,
  input  logic [DW-1:0]            wr_data,
  output logic [NREG-1:0][DW-1:0]  regs
);
  logic [NREG-1:0][DW-1:0] regs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_en) begin
      regs_q[wr_addr] <= wr_data;
    end
  end

  assign regs = regs_q;
endmodule

// File: rtl/cop_row.sv
module cop_row
  import cop_pkg::*;
#(
  parameter int DW      = 16,
  parameter int NREG    = 8,
  parameter int TAG_W   = 6,
  parameter int LAT_W   = 4,
  parameter int ROW_IDX = 0,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [TAG_W-1:0]         ld_tag,
  input  cop_fn_e                  ld_fn,
  input  logic [LAT_W-1:0]         ld_lat,
  input  logic                     rf_we,
  input  logic [RA_W-1:0]          rf_waddr,
  input  logic [NREG-1:0][DW-1:0]  regs,
  output logic                     row_vld,
  output logic [TAG_W-1:0]         row_tag,
  output logic                     row_settled,
  output logic [DW-1:0]            row_data
);
  localparam logic [RA_W-1:0] SRC_A = RA_W'(ROW_IDX % NREG);
  localparam logic [RA_W-1:0] SRC_B = RA_W'((ROW_IDX + 1) % NREG);
  localparam logic [RA_W-1:0] SRC_C = RA_W'((ROW_IDX + 2) % NREG);

  logic             vld_q;
  logic [TAG_W-1:0] tag_q;
  cop_fn_e          fn_q;
  logic [LAT_W-1:0] lat_q;
  logic [LAT_W-1:0] cnt_q;
  logic             src_touch;
  logic             restart;
  logic [LAT_W-1:0] restart_lat;
  logic [DW-1:0]    op_a, op_b, op_c, rev_a;

  assign src_touch   = rf_we && (rf_waddr == SRC_A || rf_waddr == SRC_B || rf_waddr == SRC_C);
  assign restart     = ld_en || src_touch;
  assign restart_lat = ld_en ? ld_lat : lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tag_q <= '0;
      fn_q  <= FN_SUM3;
      lat_q <= '0;
      cnt_q <= '0;
    end else begin
      if (ld_en) begin
        vld_q <= 1'b1;
        tag_q <= ld_tag;
        fn_q  <= ld_fn;
        lat_q <= ld_lat;
      end
      if (restart) begin
        cnt_q <= restart_lat;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign op_a = regs[SRC_A];
  assign op_b = regs[SRC_B];
  assign op_c = regs[SRC_C];

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      rev_a[i] = op_a[DW-1-i];
    end
  end

  always_comb begin
    unique case (fn_q)
      FN_SUM3:  row_data = op_a + op_b + op_c;
      FN_XOR3:  row_data = op_a ^ op_b ^ op_c;
      FN_REV:   row_data = rev_a;
      FN_ANDOR: row_data = (op_a & op_b) | op_c;
      default:  row_data = '0;
    endcase
  end

  assign row_vld     = vld_q;
  assign row_tag     = tag_q;
  assign row_settled = vld_q && (cnt_q == '0);

  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    row_settled && !restart |=> row_settled); // R4
  AST_RESTART_UNSETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart && (restart_lat != '0) |=> !row_settled); // R4
  AST_LOAD_SETS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> row_vld && (row_tag == $past(ld_tag))); // R10
endmodule

// File: rtl/cop_tag_match.sv
module cop_tag_match #(
  parameter int NROW  = 4,
  parameter int TAG_W = 6,
  localparam int ROW_W = $clog2(NROW)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NROW-1:0]            row_vld,
  input  logic [NROW-1:0][TAG_W-1:0] row_tag,
  input  logic [TAG_W-1:0]           op_tag,
  output logic                       any_hit,
  output logic                       multi_hit,
  output logic [ROW_W-1:0]           sel_idx
);
  logic [NROW-1:0] hits;
  logic [NROW-1:0] sel_oh;
  int unsigned     hit_cnt;

  always_comb begin
    for (int r = 0; r < NROW; r++) begin
      hits[r] = row_vld[r] && (row_tag[r] == op_tag);
    end
  end

  always_comb begin
    sel_idx = '0;
    sel_oh  = '0;
    for (int r = NROW - 1; r >= 0; r--) begin
      if (hits[r]) begin
        sel_idx = ROW_W'(r);
        sel_oh  = '0;
        sel_oh[r] = 1'b1;
      end
    end
  end

  always_comb begin
    hit_cnt = 0;
    for (int r = 0; r < NROW; r++) begin
      hit_cnt = hit_cnt + {31'd0, hits[r]};
    end
  end

  assign any_hit   = |hits;
  assign multi_hit = hit_cnt > 1;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh)); // R2
  AST_SEL_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_oh & ~hits) == '0); // R2
  AST_DUP_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit |-> (((sel_oh - 1'b1) & hits) == '0)); // R7
endmodule

// File: rtl/cop_dispatch.sv
module cop_dispatch
  import cop_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NREG  = 8,
  parameter int NROW  = 4,
  parameter int TAG_W = 6,
  parameter int LAT_W = 4,
  localparam int RA_W  = $clog2(NREG),
  localparam int ROW_W = $clog2(NROW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_we,
  input  logic [RA_W-1:0]  rf_waddr,
  input  logic [DW-1:0]    rf_wdata,
  input  logic             ld_we,
  input  logic [ROW_W-1:0] ld_row,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic [1:0]       ld_fn,
  input  logic [LAT_W-1:0] ld_lat,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [TAG_W-1:0] op_tag,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [DW-1:0]    wb_data,
  output logic [ROW_W-1:0] wb_row,
  output logic             pipe_stall,
  output logic             cfg_miss,
  output logic             dup_err
);
  logic [NREG-1:0][DW-1:0]    regs;
  logic [NROW-1:0]            row_vld;
  logic [NROW-1:0][TAG_W-1:0] row_tag;
  logic [NROW-1:0]            row_settled;
  logic [NROW-1:0][DW-1:0]    row_data;
  logic                       any_hit;
  logic                       multi_hit;
  logic [ROW_W-1:0]           sel_idx;

  cop_shadow_rf #(.DW(DW), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rf_we),
    .wr_addr (rf_waddr),
    .wr_data (rf_wdata),
    .regs    (regs)
  );

  for (genvar g = 0; g < NROW; g++) begin : g_row
    cop_row #(
      .DW(DW), .NREG(NREG), .TAG_W(TAG_W), .LAT_W(LAT_W), .ROW_IDX(g)
    ) u_row (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_en       (ld_we && (ld_row == ROW_W'(g))),
      .ld_tag      (ld_tag),
      .ld_fn       (cop_fn_e'(ld_fn)),
      .ld_lat      (ld_lat),
      .rf_we       (rf_we),
      .rf_waddr    (rf_waddr),
      .regs        (regs),
      .row_vld     (row_vld[g]),
      .row_tag     (row_tag[g]),
      .row_settled (row_settled[g]),
      .row_data    (row_data[g])
    );
  end

  cop_tag_match #(.NROW(NROW), .TAG_W(TAG_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_vld   (row_vld),
    .row_tag   (row_tag),
    .op_tag    (op_tag),
    .any_hit   (any_hit),
    .multi_hit (multi_hit),
    .sel_idx   (sel_idx)
  );

  assign wb_valid   = op_valid && any_hit && row_settled[sel_idx];
  assign wb_data    = wb_valid ? row_data[sel_idx] : '0;
  assign wb_row     = sel_idx;
  assign op_ready   = wb_valid && wb_ready;
  assign pipe_stall = op_valid && !op_ready;
  assign cfg_miss   = op_valid && !any_hit;
  assign dup_err    = op_valid && multi_hit;

  AST_MISS_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_miss |-> !wb_valid && pipe_stall); // R3
  AST_READY_NEEDS_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> wb_valid && wb_ready && !pipe_stall); // R8
  AST_DUP_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |-> !cfg_miss); // R7
endmodule

// File: tb/cop_dispatch_tb.sv
module cop_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [15:0] rf_wdata;
  logic        ld_we;
  logic [1:0]  ld_row;
  logic [5:0]  ld_tag;
  logic [1:0]  ld_fn;
  logic [3:0]  ld_lat;
  logic        op_valid;
  logic        op_ready;
  logic [5:0]  op_tag;
  logic        wb_valid;
  logic        wb_ready;
  logic [15:0] wb_data;
  logic [1:0]  wb_row;
  logic        pipe_stall;
  logic        cfg_miss;
  logic        dup_err;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;
  logic [15:0] mir [8];
  int row_fn [4];

  always #4 clk = ~clk;

  cop_dispatch u_dut (
    .clk(clk), .rst_n(rst_n),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .ld_we(ld_we), .ld_row(ld_row), .ld_tag(ld_tag), .ld_fn(ld_fn), .ld_lat(ld_lat),
    .op_valid(op_valid), .op_ready(op_ready), .op_tag(op_tag),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data), .wb_row(wb_row),
    .pipe_stall(pipe_stall), .cfg_miss(cfg_miss), .dup_err(dup_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(int row);
    logic [15:0] a, b, c, r;
    a = mir[row % 8];
    b = mir[(row + 1) % 8];
    c = mir[(row + 2) % 8];
    case (row_fn[row])
      0: r = a + b + c;
      1: r = a ^ b ^ c;
      2: for (int i = 0; i < 16; i++) r[i] = a[15-i];
      default: r = (a & b) | c;
    endcase
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic rf_write(int idx, logic [15:0] val);
    rf_we = 1'b1; rf_waddr = 3'(idx); rf_wdata = val;
    step();
    rf_we = 1'b0;
    mir[idx] = val;
  endtask

  task automatic load(int row, int tag, int fn, int lat);
    ld_we = 1'b1; ld_row = 2'(row); ld_tag = 6'(tag); ld_fn = 2'(fn); ld_lat = 4'(lat);
    step();
    ld_we = 1'b0;
    row_fn[row] = fn;
  endtask

  task automatic t_reset();
    op_valid = 1'b1; op_tag = 6'h05; wb_ready = 1'b1;
    #1;
    check("R1 miss after reset", cfg_miss, 1);
    check("R1 no wb after reset", wb_valid, 0);
    check("R1 not ready after reset", op_ready, 0);
    check("R1 no dup after reset", dup_err, 0);
    op_valid = 1'b0;
  endtask

  task automatic t_hit_nostall();
    op_valid = 1'b1; op_tag = 6'h11; wb_ready = 1'b1;
    #1;
    check("R2 hit valid", wb_valid, 1);
    check("R8 hit ready", op_ready, 1);
    check("R8 no stall", pipe_stall, 0);
    check("R2 hit row", wb_row, 0);
    check("R6 sum3 data", wb_data, model(0));
    step();
    op_valid = 1'b0;
  endtask

  task automatic t_functions();
    wb_ready = 1'b1;
    for (int r = 1; r < 4; r++) begin
      op_valid = 1'b1;
      op_tag = (r == 1) ? 6'h22 : (r == 2) ? 6'h33 : 6'h3C;
      #1;
      check("R6 fn valid", wb_valid, 1);
      check("R2 fn row", wb_row, r);
      check("R6 fn data", wb_data, model(r));
      step();
    end
    op_valid = 1'b0;
  endtask

  task automatic t_late_operand();
    int stalls;
    rf_write(1, 16'h7777);
    op_valid = 1'b1; op_tag = 6'h11; wb_ready = 1'b1;
    stalls = 0;
    #1;
    for (int k = 0; k < 10 && !wb_valid; k++) begin
      check("R4 stall while settling", pipe_stall, 1);
      stalls++;
      step();
      #1;
    end
    check("R4 stall count", stalls, 2);
    check("R9 new operand data", wb_data, model(0));
    step();
    op_valid = 1'b0;
  endtask

  task automatic t_ignored_write();
    op_valid = 1'b1; op_tag = 6'h11; wb_ready = 1'b1;
    rf_we = 1'b1; rf_waddr = 3'd6; rf_wdata = 16'hDEAD;
    step();
    rf_we = 1'b0; mir[6] = 16'hDEAD;
    #1;
    check("R5 foreign write no stall", wb_valid, 1);
    check("R5 foreign write data", wb_data, model(0));
    step();
    op_valid = 1'b0;
  endtask

  task automatic t_miss_then_load();
    op_valid = 1'b1; op_tag = 6'h2A; wb_ready = 1'b1;
    #1;
    check("R3 miss raised", cfg_miss, 1);
    check("R3 miss stalls", op_ready, 0);
    ld_we = 1'b1; ld_row = 2'd1; ld_tag = 6'h2A; ld_fn = 2'd1; ld_lat = 4'd0;
    #1;
    check("R3 miss held in load cycle", cfg_miss, 1);
    step();
    ld_we = 1'b0; row_fn[1] = 1;
    #1;
    check("R3 miss cleared next cycle", cfg_miss, 0);
    check("R3 result after load", wb_valid, 1);
    check("R3 loaded row data", wb_data, model(1));
    step();
    op_tag = 6'h22;
    #1;
    check("R10 old tag misses", cfg_miss, 1);
    op_valid = 1'b0;
    load(1, 'h22, 1, 0);
  endtask

  task automatic t_back_to_back();
    wb_ready = 1'b1; op_valid = 1'b1; op_tag = 6'h11;
    #1;
    check("R8 b2b first ready", op_ready, 1);
    check("R8 b2b first data", wb_data, model(0));
    step();
    op_tag = 6'h33;
    #1;
    check("R8 b2b second ready", op_ready, 1);
    check("R8 b2b second row", wb_row, 2);
    check("R8 b2b second data", wb_data, model(2));
    step();
    op_valid = 1'b0;
  endtask

  task automatic t_backpressure();
    op_valid = 1'b1; op_tag = 6'h22; wb_ready = 1'b0;
    #1;
    check("R8 bp valid", wb_valid, 1);
    check("R8 bp not ready", op_ready, 0);
    check("R8 bp stall", pipe_stall, 1);
    step();
    wb_ready = 1'b1;
    #1;
    check("R8 bp released", op_ready, 1);
    step();
    op_valid = 1'b0;
  endtask

  task automatic t_dup();
    load(3, 'h33, 3, 0);
    op_valid = 1'b1; op_tag = 6'h33; wb_ready = 1'b1;
    #1;
    check("R7 dup flagged", dup_err, 1);
    check("R7 lowest row", wb_row, 2);
    check("R7 lowest row data", wb_data, model(2));
    op_valid = 1'b0;
    load(3, 'h3C, 3, 0);
    op_valid = 1'b1;
    #1;
    check("R7 dup cleared", dup_err, 0);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rf_we = 1'b0; rf_waddr = '0; rf_wdata = '0;
    ld_we = 1'b0; ld_row = '0; ld_tag = '0; ld_fn = '0; ld_lat = '0;
    op_valid = 1'b0; op_tag = '0; wb_ready = 1'b0;
    for (int i = 0; i < 8; i++) mir[i] = '0;
    for (int i = 0; i < 4; i++) row_fn[i] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();
    t_reset();
    rf_write(0, 16'h1234);
    rf_write(1, 16'h0F0F);
    rf_write(2, 16'h00FF);
    rf_write(3, 16'hA5A5);
    rf_write(4, 16'h8001);
    rf_write(5, 16'h0330);
    load(0, 'h11, 0, 2);
    load(1, 'h22, 1, 0);
    load(2, 'h33, 2, 1);
    load(3, 'h3C, 3, 3);
    repeat (4) step();
    t_hit_nostall();
    t_functions();
    t_late_operand();
    t_ignored_write();
    t_miss_then_load();
    t_back_to_back();
    t_backpressure();
    t_dup();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule